// File: doc/BRIEF.md
# Page-Buffered EEPROM Write Engine

This block is a clocked model of the control logic inside a parallel EEPROM that a host drives like a static RAM. Three active-low strobes (chip select, write strobe, read strobe), an address bus and a byte-wide data bus are sampled on the system clock. Each completed write strobe drops one byte into a page buffer. A retriggerable load timer decides when the page is closed. After that, a fixed programming interval runs and the buffered bytes are then committed into an internal register array.

While a write is in flight, a read returns a status byte. Its bit 7 is the inverse of the last byte loaded, so software can poll for completion. Once the commit is done, reads return the true stored data. Strobes that arrive during the programming interval are dropped.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset `busy` and `dout_en` are 0, and every array location reads 0xFF.
- R2: A write strobe counts only while `oe_n` is high. A chip-select/write-strobe overlap taken with `oe_n` low loads nothing and leaves `busy` at 0.
- R3: A write is active on every clock edge where `ce_n`=0, `we_n`=0 and `oe_n`=1. The address is taken on the first clock edge of that window. The data is the `din` value sampled on the last edge before the window closes. Address or data changes after those points do not matter.
- R4: A write works the same whether `ce_n` or `we_n` is the strobe that opens and closes the window.
- R5: Each active write edge, and each byte load, restarts the load timer from zero. A byte that arrives before the timer expires joins the current page.
- R6: Suppose the last byte loads on clock edge E and no further write is active. Then programming starts after LOAD_TIMEOUT edges and lasts PROG_CYCLES edges. `busy` is 1 from the edge after the first byte load through edge E+LOAD_TIMEOUT+PROG_CYCLES-1, and it is 0 after edge E+LOAD_TIMEOUT+PROG_CYCLES.
- R7: A read taken while `busy` is 1 returns the last loaded byte with bit 7 inverted, whatever the address.
- R8: The page is the address with its low PAGE_BITS bits cleared, taken from the last byte loaded. On commit, only the offsets loaded since the previous commit are written. All other locations keep their contents.
- R9: A write window that closes while programming is running is ignored: nothing is buffered and nothing is committed for it.
- R10: `dout_en` is 1 one cycle after an edge that saw `ce_n`=0, `oe_n`=0 and `we_n`=1, and 0 otherwise. `dout` carries the read result with the same one-cycle latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data or polling status |
| dout_en | output | 1 | Read data valid (drive enable for the data bus) |
| busy | output | 1 | Page load or programming in progress |

## Verification
Several rules are checked by assertions on every cycle:
- a byte load only follows an edge where the read strobe was high;
- a loaded offset is marked valid;
- the buffer's valid set is frozen during programming until the commit clears it;
- an active write holds the sequencer in its load state;
- `busy` only falls out of programming;
- the read-enable timing and the inverted bit 7 of the polling byte hold.

Other behaviour is visible only through the bench's scenarios:
- the exact edge on which `busy` drops;
- which address and which data a strobe window captures;
- that chip-select-controlled writes behave like write-strobe-controlled ones;
- that the retrigger keeps a spread-out page together;
- that unloaded offsets and writes made during programming leave the array untouched.

// File: rtl/eep_pkg.sv
// Shared types for the page-buffered EEPROM write engine.
package eep_pkg;
    // Sequencer phases: idle, collecting page bytes, programming the array
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } eep_state_e;
endpackage

// File: rtl/eep_strobe_decoder.sv
// Strobe decoder: turns the sampled chip-select / write / read strobes into a
// write-active level and a one-cycle byte-load pulse.
// Assumes the strobes are already synchronous to clk.
// The address is latched on the first active edge. The data is the value
// registered on the last active edge.
module eep_strobe_decoder #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_active,
    output logic              load_pulse,
    output logic [ADDR_W-1:0] load_addr,
    output logic [DATA_W-1:0] load_data
);
    logic              act_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q;

    assign wr_active  = ~ce_n & ~we_n & oe_n;
    assign load_pulse = act_q & ~wr_active;
    assign load_addr  = addr_q;
    assign load_data  = din_q;

    // Track the write window, latch the address at its opening, keep the last data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            addr_q <= '0;
            din_q  <= '0;
        end else begin
            act_q <= wr_active;
            if (wr_active) din_q <= din;
            if (wr_active && !act_q) addr_q <= addr;
        end
    end

    // R2
    load_needs_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |-> $past(oe_n));
endmodule

// File: rtl/eep_sequencer.sv
// Write sequencer: a retriggerable load timer followed by a fixed programming
// interval. Both lengths are counted in clock cycles by one shared counter.
// Assumes LOAD_TIMEOUT and PROG_CYCLES are both at least 2.
module eep_sequencer
    import eep_pkg::*;
#(
    parameter int LOAD_TIMEOUT = 100,
    parameter int PROG_CYCLES  = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_active,
    input  logic load_pulse,
    output logic accept,
    output logic commit,
    output logic in_prog,
    output logic busy
);
    localparam int MAXC = (LOAD_TIMEOUT > PROG_CYCLES) ? LOAD_TIMEOUT : PROG_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LOAD_LAST = CW'(LOAD_TIMEOUT - 1);
    localparam logic [CW-1:0] PROG_LAST = CW'(PROG_CYCLES - 1);

    eep_state_e     state;
    logic [CW-1:0]  cnt;

    assign accept  = load_pulse && (state != ST_PROG);
    assign in_prog = (state == ST_PROG);
    assign commit  = in_prog && (cnt == PROG_LAST);
    assign busy    = (state != ST_IDLE);

    // Phase control with the retriggerable load timer and the programming timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (accept) state <= ST_LOAD;
                end
                ST_LOAD: begin
                    if (wr_active || accept) begin
                        cnt <= '0;
                    end else if (cnt == LOAD_LAST) begin
                        cnt   <= '0;
                        state <= ST_PROG;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (cnt == PROG_LAST) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    cnt   <= '0;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // R5
    strobe_holds_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && wr_active) |=> (state == ST_LOAD));

    // R6
    busy_ends_from_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(in_prog));
endmodule

// File: rtl/eep_page_buffer.sv
// Page buffer: holds up to one page of loaded bytes with a valid bit per
// offset, the page number of the last load and the last loaded byte.
// Assumes accept never coincides with commit (the sequencer blocks loads
// while programming).
module eep_page_buffer #(
    parameter int ADDR_W    = 9,
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 7
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  accept,
    input  logic                                  commit,
    input  logic                                  in_prog,
    input  logic [ADDR_W-1:0]                     load_addr,
    input  logic [DATA_W-1:0]                     load_data,
    output logic [ADDR_W-PAGE_BITS-1:0]           page_q,
    output logic [(1<<PAGE_BITS)-1:0][DATA_W-1:0] pbuf,
    output logic [(1<<PAGE_BITS)-1:0]             pvalid,
    output logic [DATA_W-1:0]                     last_data
);
    logic [PAGE_BITS-1:0] offset;
    assign offset = load_addr[PAGE_BITS-1:0];

    // Store accepted bytes, clear the valid set after a commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pbuf      <= '0;
            pvalid    <= '0;
            page_q    <= '0;
            last_data <= '0;
        end else if (accept) begin
            pbuf[offset]   <= load_data;
            pvalid[offset] <= 1'b1;
            page_q         <= load_addr[ADDR_W-1:PAGE_BITS];
            last_data      <= load_data;
        end else if (commit) begin
            pvalid <= '0;
        end
    end

    // R8
    loaded_offset_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> pvalid[$past(offset)]);

    // R9
    frozen_while_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_prog && !commit) |=> $stable(pvalid));
endmodule

// File: rtl/eep_cell_array.sv
// Cell array: a register array that comes out of reset erased (all ones).
// On commit it writes every valid buffer offset into the selected page.
// Reads are combinational.
module eep_cell_array #(
    parameter int ADDR_W    = 9,
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 7
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  commit,
    input  logic [ADDR_W-PAGE_BITS-1:0]           page,
    input  logic [(1<<PAGE_BITS)-1:0][DATA_W-1:0] pbuf,
    input  logic [(1<<PAGE_BITS)-1:0]             pvalid,
    input  logic [ADDR_W-1:0]                     raddr,
    output logic [DATA_W-1:0]                     rdata
);
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int PAGE_SZ = 1 << PAGE_BITS;

    logic [DATA_W-1:0] mem [DEPTH];

    assign rdata = mem[raddr];

    // Erase on reset, write the valid bytes of the page on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '1;
        end else if (commit) begin
            for (int i = 0; i < PAGE_SZ; i++) begin
                if (pvalid[i]) mem[{page, PAGE_BITS'(i)}] <= pbuf[i];
            end
        end
    end
endmodule

// File: rtl/eeprom_page_writer.sv
// Top level: SRAM-style strobe front end, page buffer, write sequencer and
// cell array. It also registers the read port. While busy, a read returns the
// last loaded byte with bit 7 inverted (completion polling).
module eeprom_page_writer #(
    parameter int ADDR_W       = 9,
    parameter int DATA_W       = 8,
    parameter int PAGE_BITS    = 7,
    parameter int LOAD_TIMEOUT = 100,
    parameter int PROG_CYCLES  = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              busy
);
    localparam int PAGE_SZ = 1 << PAGE_BITS;
    localparam int PAGE_W  = ADDR_W - PAGE_BITS;

    logic                            wr_active, load_pulse, accept, commit, in_prog;
    logic [ADDR_W-1:0]               load_addr;
    logic [DATA_W-1:0]               load_data, last_data, rdata;
    logic [PAGE_W-1:0]               page_q;
    logic [PAGE_SZ-1:0][DATA_W-1:0]  pbuf;
    logic [PAGE_SZ-1:0]              pvalid;
    logic                            rd_req;

    eep_strobe_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .wr_active(wr_active), .load_pulse(load_pulse),
        .load_addr(load_addr), .load_data(load_data)
    );

    eep_sequencer #(.LOAD_TIMEOUT(LOAD_TIMEOUT), .PROG_CYCLES(PROG_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_active(wr_active), .load_pulse(load_pulse),
        .accept(accept), .commit(commit), .in_prog(in_prog), .busy(busy)
    );

    eep_page_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_buf (
        .clk(clk), .rst_n(rst_n), .accept(accept), .commit(commit), .in_prog(in_prog),
        .load_addr(load_addr), .load_data(load_data), .page_q(page_q),
        .pbuf(pbuf), .pvalid(pvalid), .last_data(last_data)
    );

    eep_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_arr (
        .clk(clk), .rst_n(rst_n), .commit(commit), .page(page_q),
        .pbuf(pbuf), .pvalid(pvalid), .raddr(addr), .rdata(rdata)
    );

    assign rd_req = ~ce_n & ~oe_n & we_n;

    // Registered read port: true data when idle, polling byte while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else begin
            dout_en <= rd_req;
            if (rd_req) begin
                dout <= busy ? {~last_data[DATA_W-1], last_data[DATA_W-2:0]} : rdata;
            end
        end
    end

    // R10
    read_enable_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(!ce_n && !oe_n && we_n));

    // R7
    poll_bit_inverted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && $past(busy)) |-> (dout[DATA_W-1] != $past(last_data[DATA_W-1])));
endmodule

// File: tb/tb_eeprom_page_writer.sv
// Scoreboard bench: read tasks push expected bytes into a queue, and a monitor
// pops and compares them whenever dout_en is seen.
module tb_eeprom_page_writer;
    localparam int AW = 9;
    localparam int DW = 8;
    localparam int T  = 100;
    localparam int P  = 200;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en, busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #2.5 clk = ~clk;

    eeprom_page_writer #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(7),
                         .LOAD_TIMEOUT(T), .PROG_CYCLES(P)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compares every read result against the scoreboard
    always @(posedge clk) begin
        #1;
        if (rst_n && dout_en) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R10: actual %0h expected no read", dout);
            end else begin
                automatic logic [DW-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, dout, e);
            end
        end
    end

    task automatic idle_bus();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        idle_bus();
    endtask

    // Write-strobe controlled byte; address moves to a2 mid-pulse, data junk at close
    task automatic wr_we(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [AW-1:0] a2,
                         input logic oe_lvl);
        @(negedge clk);
        oe_n = oe_lvl; ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        addr = a2;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1; din = 8'h5A;
    endtask

    // Chip-select controlled byte: write strobe low first, chip select pulses
    task automatic wr_ce(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        we_n = 1'b0; ce_n = 1'b1; addr = a; din = d;
        @(negedge clk);
        ce_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        ce_n = 1'b1; din = 8'hC3;
        @(negedge clk);
        we_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        #(5 * 20000);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 dout_en", dout_en, 0);
        rd(9'h000, 8'hFF, "R1 erased");

        // R2 write with read strobe low is not a write
        wr_we(9'h010, 8'h42, 9'h010, 1'b0);
        @(negedge clk);
        check("R2 busy", busy, 0);
        rd(9'h010, 8'hFF, "R2 no write");

        // R3 address taken at window opening, data before window closes; R6 timing
        wr_we(9'h005, 8'hA5, 9'h006, 1'b1);
        repeat (T + P) @(posedge clk);
        #1 check("R6 busy before end", busy, 1);
        @(posedge clk);
        #1 check("R6 busy after end", busy, 0);
        rd(9'h005, 8'hA5, "R3 captured byte");
        rd(9'h006, 8'hFF, "R3 later address unused");

        // R10 no read with read strobe high
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        check("R10 no read", dout_en, 0);
        idle_bus();

        // R4/R5 chip-select writes spread across the load timer
        wr_ce(9'h080, 8'h11);
        repeat (50) @(negedge clk);
        wr_ce(9'h081, 8'h22);
        repeat (50) @(negedge clk);
        wr_ce(9'h0FF, 8'h3C);
        repeat (20) @(negedge clk);
        check("R5 busy in load", busy, 1);
        // R7 polling read during load and programming
        rd(9'h000, 8'hBC, "R7 poll in load");
        repeat (100) @(negedge clk);
        rd(9'h081, 8'hBC, "R7 poll in prog");
        // R9 write during programming is dropped
        wr_we(9'h082, 8'h77, 9'h082, 1'b1);
        while (busy) @(negedge clk);
        rd(9'h080, 8'h11, "R4 first byte");
        rd(9'h081, 8'h22, "R5 second byte");
        rd(9'h0FF, 8'h3C, "R5 last offset");
        rd(9'h082, 8'hFF, "R9 dropped write");
        rd(9'h083, 8'hFF, "R8 unloaded offset");
        rd(9'h005, 8'hA5, "R8 other page kept");

        // R8 page from last load: second byte moves the page
        wr_we(9'h101, 8'h0F, 9'h101, 1'b1);
        wr_we(9'h182, 8'hF0, 9'h182, 1'b1);
        while (busy) @(negedge clk);
        rd(9'h181, 8'h0F, "R8 page follows last load");
        rd(9'h182, 8'hF0, "R8 second byte");
        rd(9'h101, 8'hFF, "R8 old page untouched");

        repeat (3) @(negedge clk);
        check("R10 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule